// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the pointer state of one descriptor ring shared between software and a DMA engine. Descriptors are 32 bytes each. The block holds the ring's base address, its depth in descriptors, a write (head) pointer and a read (tail) pointer. From these it derives occupancy, free space, empty and full. Software owns one pointer and moves it with register writes. The hardware side owns the other pointer and advances it one slot per accepted strobe. The hardware side is also given the address of the descriptor at its pointer.

The parameter `SW_PRODUCES` picks the direction. With 1, software posts entries by moving the head, and the hardware consumes by moving the tail; this suits a receive free ring or a transmit busy ring. With 0, the hardware produces by moving the head, and software releases entries by moving the tail; this suits a receive busy ring or a transmit release ring. One slot is always left unused, so a full ring holds depth − 1 entries and never looks empty.

Registers are addressed by a 3-bit word index:

| Index | Name | Access | Contents |
|---|---|---|---|
| 0 | base | write gated, read | base address |
| 1 | size | write gated, read | descriptor count × 8 |
| 2 | unlock | read/write | bit 1 unlocks size, bit 2 unlocks base |
| 3 | control | read/write | bit 0 = run |
| 4 | head | read/write | head pointer in bytes |
| 5 | tail | read/write | tail pointer in bytes |
| 6 | status | read only | see R9 |

Top module: `ring_queue_mgr`

## Requirements
- R1: After reset the base reads 0, the size register reads DEPTH_MAX×8, the unlock and control registers read 0, both pointers read 0, the status shows empty, and hw_ready is 0.
- R2: A write to register 0 (base) takes effect only when unlock bit 2 is set. Otherwise it is ignored. The unlock register (index 2) keeps only bits 1 and 2 and reads them back in place.
- R3: A write to register 1 (size) carries the descriptor count shifted left by 3. It takes effect only when unlock bit 1 is set and the count lies in 2..DEPTH_MAX. Otherwise it is ignored. Register 1 reads back as count×8.
- R4: An effective base or size write returns both pointers to index 0 in the same cycle it takes effect.
- R5: The software-owned pointer register takes a byte offset, and its index is value>>5. The write loads the pointer only when run (register 3 bit 0) is 1 and the index is below the depth. Otherwise it is ignored. Writes to the hardware-owned pointer register, and to indices 6 and 7, are always ignored.
- R6: hw_desc_addr equals base + 32 × (hardware-owned pointer index), modulo 2^ADDR_W.
- R7: hw_ready is run AND not-empty when software produces (SW_PRODUCES=1). It is run AND not-full when hardware produces (SW_PRODUCES=0).
- R8: A one-cycle hw_step moves the hardware-owned pointer on by one only while hw_ready is 1. The pointer wraps to 0 when the incremented index reaches the depth. hw_step has no effect while hw_ready is 0.
- R9: Status register 6 reads as follows. Bit 0 is empty (head = tail). Bit 1 is full (occupancy = depth − 1). Bits 15:8 hold the occupancy, (head − tail) mod depth. Bits 23:16 hold the free space, depth − occupancy. All other bits read 0.
- R10: Registers 4 and 5 read back the head and tail index shifted left by 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_waddr | input | 3 | register write index |
| reg_wdata | input | 32 | register write data |
| reg_raddr | input | 3 | register read index |
| reg_rdata | output | 32 | register read data (combinational) |
| hw_ready | output | 1 | hardware side may step |
| hw_step | input | 1 | hardware side advances its pointer |
| hw_desc_addr | output | ADDR_W | address of the descriptor at the hardware pointer |

## Verification
A register write or an accepted hw_step is seen on the edge that captures it. Its effect is visible one cycle later on reg_rdata, hw_ready and hw_desc_addr, because the read path and the hardware outputs are combinational from the registered state. The bench drives each stimulus at a falling edge and removes it at the next falling edge. It then samples every output and every read index one nanosecond after later falling edges, while no stimulus is applied. Two instances, one per direction, share the register bus. They are compared against an arithmetic model through a long mixed sweep of depths, pointer writes, gated writes and steps.

// File: rtl/ring_pkg.sv
// Package: shared register indices and constants for the ring pointer manager.
// Assumes descriptors of 32 bytes and a size field written as count << 3.
package ring_pkg;
    typedef enum logic [2:0] {
        RA_BASE   = 3'd0,
        RA_SIZE   = 3'd1,
        RA_UNLOCK = 3'd2,
        RA_CTRL   = 3'd3,
        RA_HEAD   = 3'd4,
        RA_TAIL   = 3'd5,
        RA_STAT   = 3'd6
    } ring_reg_e;

    localparam int DESC_SHIFT       = 5;
    localparam int SIZE_SHIFT       = 3;
    localparam int UNLOCK_SIZE_BIT  = 1;
    localparam int UNLOCK_BASE_BIT  = 2;
    localparam int MIN_DEPTH        = 2;
endpackage

// File: rtl/ring_cfg_regs.sv
// Module: configuration registers of one ring (base, size, unlock, run).
// Base and size writes only land while their unlock bit is set; an accepted
// one raises reconfig for that cycle so the pointers can be cleared.
// Assumes one register write per cycle at most.
module ring_cfg_regs
    import ring_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DEPTH_MAX = 64,
    parameter int CNT_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_waddr,
    input  logic [31:0]       reg_wdata,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  depth,
    output logic              unlock_size,
    output logic              unlock_base,
    output logic              run,
    output logic              reconfig
);
    logic [31:0] size_cnt;
    logic        size_ok;
    logic        base_hit;
    logic        size_hit;

    // Decode which gated configuration writes are accepted this cycle.
    always_comb begin
        size_cnt = reg_wdata >> SIZE_SHIFT;
        size_ok  = (size_cnt >= 32'(MIN_DEPTH)) && (size_cnt <= 32'(DEPTH_MAX));
        base_hit = reg_we && (reg_waddr == RA_BASE) && unlock_base;
        size_hit = reg_we && (reg_waddr == RA_SIZE) && unlock_size && size_ok;
        reconfig = base_hit || size_hit;
    end

    // Hold base and depth; update only on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base  <= '0;
            depth <= CNT_W'(DEPTH_MAX);
        end else begin
            if (base_hit) base  <= reg_wdata[ADDR_W-1:0];
            if (size_hit) depth <= CNT_W'(size_cnt);
        end
    end

    // Hold the unlock bits and the run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock_size <= 1'b0;
            unlock_base <= 1'b0;
            run         <= 1'b0;
        end else if (reg_we) begin
            if (reg_waddr == RA_UNLOCK) begin
                unlock_size <= reg_wdata[UNLOCK_SIZE_BIT];
                unlock_base <= reg_wdata[UNLOCK_BASE_BIT];
            end
            if (reg_waddr == RA_CTRL) run <= reg_wdata[0];
        end
    end

    p_base_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_waddr == RA_BASE && unlock_base) |=> $stable(base));

    p_size_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_waddr == RA_SIZE && unlock_size) |=> $stable(depth));

    p_size_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig |=> (depth >= CNT_W'(MIN_DEPTH)) && (depth <= CNT_W'(DEPTH_MAX)));
endmodule

// File: rtl/ring_ptr.sv
// Module: one ring pointer index with clear, load and wrapping step.
// Priority is clear, then load, then step. Assumes load_idx < depth and
// that depth only changes in a cycle where clear is also raised.
module ring_ptr #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             step,
    input  logic [CNT_W-1:0] depth,
    output logic [IDX_W-1:0] idx
);
    logic [CNT_W-1:0] inc;

    // Compute the incremented index in the wider count domain.
    always_comb inc = CNT_W'(idx) + CNT_W'(1);

    // Update the index with wrap at depth.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx <= '0;
        end else if (load) begin
            idx <= load_idx;
        end else if (step) begin
            idx <= (inc == depth) ? '0 : inc[IDX_W-1:0];
        end
    end

    p_idx_below_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(idx) < depth);

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !load && CNT_W'(idx) == depth - CNT_W'(1)) |=> idx == '0);
endmodule

// File: rtl/ring_occupancy.sv
// Module: derives occupancy, free space, empty and full from the two indices.
// Assumes both indices are below depth and depth is at least 2.
module ring_occupancy #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [CNT_W-1:0] depth,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] space,
    output logic             empty,
    output logic             full
);
    // Modular distance from tail to head, plus derived flags.
    always_comb begin
        if (wr_idx >= rd_idx) occ = CNT_W'(wr_idx) - CNT_W'(rd_idx);
        else                  occ = depth - CNT_W'(rd_idx) + CNT_W'(wr_idx);
        space = depth - occ;
        empty = (wr_idx == rd_idx);
        full  = (occ == depth - CNT_W'(1));
    end

    p_not_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    p_occ_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        occ < depth);
endmodule

// File: rtl/ring_queue_mgr.sv
// Module: top of the ring pointer manager. Holds configuration, the head and
// tail pointers, and the register read path; SW_PRODUCES picks which side
// owns which pointer. Assumes one register write per cycle and a hw_step
// strobe that the caller only means to count when hw_ready is high.
module ring_queue_mgr
    import ring_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DEPTH_MAX   = 64,
    parameter bit SW_PRODUCES = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [31:0]       reg_rdata,
    output logic              hw_ready,
    input  logic              hw_step,
    output logic [ADDR_W-1:0] hw_desc_addr
);
    localparam int IDX_W = $clog2(DEPTH_MAX);
    localparam int CNT_W = IDX_W + 1;
    localparam logic [2:0] SW_REG = SW_PRODUCES ? RA_HEAD : RA_TAIL;

    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  depth;
    logic              unlock_size, unlock_base, run, reconfig;
    logic [IDX_W-1:0]  wr_idx, rd_idx, hw_idx, sw_idx;
    logic [CNT_W-1:0]  occ, space;
    logic              empty, full;
    logic              sw_load, hw_go;
    logic              wr_load, wr_step, rd_load, rd_step;

    ring_cfg_regs #(.ADDR_W(ADDR_W), .DEPTH_MAX(DEPTH_MAX), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .base(base), .depth(depth),
        .unlock_size(unlock_size), .unlock_base(unlock_base), .run(run),
        .reconfig(reconfig)
    );

    // Qualify the software pointer write: running and index inside the ring.
    always_comb begin
        sw_idx  = reg_wdata[DESC_SHIFT +: IDX_W];
        sw_load = reg_we && (reg_waddr == SW_REG) && run
                  && ((reg_wdata >> DESC_SHIFT) < 32'(depth));
        hw_go   = hw_step && hw_ready;
    end

    generate
        if (SW_PRODUCES) begin : g_sw_head
            // Software posts at the head; hardware consumes from the tail.
            always_comb begin
                wr_load  = sw_load;
                wr_step  = 1'b0;
                rd_load  = 1'b0;
                rd_step  = hw_go;
                hw_idx   = rd_idx;
                hw_ready = run && !empty;
            end
        end else begin : g_hw_head
            // Hardware produces at the head; software releases at the tail.
            always_comb begin
                wr_load  = 1'b0;
                wr_step  = hw_go;
                rd_load  = sw_load;
                rd_step  = 1'b0;
                hw_idx   = wr_idx;
                hw_ready = run && !full;
            end
        end
    endgenerate

    ring_ptr #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_head (
        .clk(clk), .rst_n(rst_n), .clear(reconfig), .load(wr_load),
        .load_idx(sw_idx), .step(wr_step), .depth(depth), .idx(wr_idx)
    );

    ring_ptr #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_tail (
        .clk(clk), .rst_n(rst_n), .clear(reconfig), .load(rd_load),
        .load_idx(sw_idx), .step(rd_step), .depth(depth), .idx(rd_idx)
    );

    ring_occupancy #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_occ (
        .clk(clk), .rst_n(rst_n), .wr_idx(wr_idx), .rd_idx(rd_idx),
        .depth(depth), .occ(occ), .space(space), .empty(empty), .full(full)
    );

    // Address of the descriptor at the hardware-owned pointer.
    always_comb hw_desc_addr = base + (ADDR_W'(hw_idx) << DESC_SHIFT);

    // Register read multiplexer.
    always_comb begin
        unique case (reg_raddr)
            RA_BASE:   reg_rdata = 32'(base);
            RA_SIZE:   reg_rdata = 32'(depth) << SIZE_SHIFT;
            RA_UNLOCK: reg_rdata = {29'd0, unlock_base, unlock_size, 1'b0};
            RA_CTRL:   reg_rdata = {31'd0, run};
            RA_HEAD:   reg_rdata = 32'(wr_idx) << DESC_SHIFT;
            RA_TAIL:   reg_rdata = 32'(rd_idx) << DESC_SHIFT;
            RA_STAT:   reg_rdata = {8'd0, 8'(space), 8'(occ), 6'd0, full, empty};
            default:   reg_rdata = 32'd0;
        endcase
    end

    p_hold_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_step && !hw_ready && !reconfig) |=> $stable(hw_idx));

    p_sw_ignored_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr == SW_REG && !run) |=> $stable(sw_idx) || $stable(SW_PRODUCES ? wr_idx : rd_idx));

    p_reconfig_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig |=> (wr_idx == '0) && (rd_idx == '0));

    p_ready_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !hw_ready);
endmodule

// File: tb/ring_queue_mgr_tb.sv
// Bench: two instances (software-produces and hardware-produces) on one
// register bus, checked against an arithmetic model after every operation.
module ring_queue_mgr_tb;
    localparam int DMAX = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] rdata_c, rdata_p;
    logic        ready_c, ready_p;
    logic        step_c = 1'b0, step_p = 1'b0;
    logic [31:0] addr_c, addr_p;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    string phase = "R1 reset";

    // model state
    logic [31:0] m_base;
    int m_depth, m_cw, m_cr, m_pw, m_pr;
    bit m_us, m_ub, m_run;

    always #2 clk = ~clk;

    ring_queue_mgr #(.ADDR_W(32), .DEPTH_MAX(DMAX), .SW_PRODUCES(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(rdata_c),
        .hw_ready(ready_c), .hw_step(step_c), .hw_desc_addr(addr_c));

    ring_queue_mgr #(.ADDR_W(32), .DEPTH_MAX(DMAX), .SW_PRODUCES(1'b0)) u_dut_p (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(rdata_p),
        .hw_ready(ready_p), .hw_step(step_p), .hw_desc_addr(addr_p));

    function automatic int occ_of(int w, int r);
        return (w >= r) ? (w - r) : (m_depth - r + w);
    endfunction

    function automatic logic [31:0] exp_reg(bit prod_hw, int a);
        int w, r, o;
        w = prod_hw ? m_pw : m_cw;
        r = prod_hw ? m_pr : m_cr;
        o = occ_of(w, r);
        case (a)
            0: return m_base;
            1: return 32'(m_depth) << 3;
            2: return {29'd0, m_ub, m_us, 1'b0};
            3: return {31'd0, m_run};
            4: return 32'(w) << 5;
            5: return 32'(r) << 5;
            6: return (32'(m_depth - o) << 16) | (32'(o) << 8)
                      | ((o == m_depth - 1) ? 32'd2 : 32'd0) | ((w == r) ? 32'd1 : 32'd0);
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s [%s]: actual %h expected %h", tag, phase, act, exp);
        end
    endtask

    // Compare every read index and both hardware outputs of both instances.
    task automatic check_all();
        bit rc, rp;
        rc = m_run && (m_cw != m_cr);
        rp = m_run && (occ_of(m_pw, m_pr) != m_depth - 1);
        chk("R7 ready sw-produces", 32'(ready_c), 32'(rc));
        chk("R7 ready hw-produces", 32'(ready_p), 32'(rp));
        chk("R6 desc addr sw-produces", addr_c, m_base + (32'(m_cr) << 5));
        chk("R6 desc addr hw-produces", addr_p, m_base + (32'(m_pw) << 5));
        for (int a = 0; a < 8; a++) begin
            string tag;
            @(negedge clk);
            reg_raddr = 3'(a);
            #1;
            case (a)
                0: tag = "R2 base";
                1: tag = "R3 size";
                2: tag = "R2 unlock";
                3: tag = "R5 run";
                4: tag = "R4 R5 R8 R10 head";
                5: tag = "R4 R5 R8 R10 tail";
                6: tag = "R9 status";
                default: tag = "R5 unused index";
            endcase
            chk(tag, rdata_c, exp_reg(1'b0, a));
            chk(tag, rdata_p, exp_reg(1'b1, a));
        end
    endtask

    task automatic model_write(int a, logic [31:0] d);
        int idx;
        idx = (d >> 5) > 32'(DMAX) ? DMAX + 1 : int'(d >> 5);
        case (a)
            0: if (m_ub) begin m_base = d; m_cw = 0; m_cr = 0; m_pw = 0; m_pr = 0; end
            1: if (m_us && (d >> 3) >= 2 && (d >> 3) <= 32'(DMAX)) begin
                   m_depth = int'(d >> 3); m_cw = 0; m_cr = 0; m_pw = 0; m_pr = 0;
               end
            2: begin m_us = d[1]; m_ub = d[2]; end
            3: m_run = d[0];
            4: if (m_run && idx < m_depth) m_cw = idx;
            5: if (m_run && idx < m_depth) m_pr = idx;
            default: ;
        endcase
    endtask

    task automatic do_write(int a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        model_write(a, d);
        check_all();
    endtask

    task automatic do_step(bit sc, bit sp);
        @(negedge clk);
        step_c = sc; step_p = sp;
        @(negedge clk);
        step_c = 1'b0; step_p = 1'b0;
        if (sc && m_run && m_cw != m_cr) m_cr = (m_cr + 1) % m_depth;
        if (sp && m_run && occ_of(m_pw, m_pr) != m_depth - 1) m_pw = (m_pw + 1) % m_depth;
        check_all();
    endtask

    task automatic set_size(int cnt);
        do_write(2, 32'h2);
        do_write(1, 32'(cnt) << 3);
        do_write(2, 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_base = '0; m_depth = DMAX; m_cw = 0; m_cr = 0; m_pw = 0; m_pr = 0;
        m_us = 0; m_ub = 0; m_run = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        check_all();   // R1 reset state

        phase = "R2 gated base";
        do_write(0, 32'h1234_5600);          // locked: ignored
        do_write(2, 32'h4);
        do_write(0, 32'h1234_5600);
        do_write(2, 32'h0);

        phase = "R3 gated size";
        do_write(1, 32'd5 << 3);              // locked: ignored
        do_write(2, 32'h2);
        do_write(1, 32'd1 << 3);              // too small
        do_write(1, 32'd65 << 3);             // too large
        do_write(1, 32'd0);
        do_write(1, 32'd4 << 3);
        do_write(2, 32'h0);

        phase = "R5 stopped";
        do_write(4, 32'd2 << 5);              // run=0: ignored
        do_write(5, 32'd1 << 5);
        do_step(1'b1, 1'b1);                  // R7 not ready while stopped

        phase = "R8 wrap";
        do_write(3, 32'h1);
        do_write(4, 32'd3 << 5);
        for (int k = 0; k < 6; k++) do_step(1'b1, 1'b1);
        do_write(4, 32'd1 << 5);
        for (int k = 0; k < 4; k++) do_step(1'b1, 1'b1);
        set_size(2);                          // R4 clears, smallest ring
        for (int k = 0; k < 3; k++) begin
            do_write(4, 32'd1 << 5 | 32'h1f);
            do_step(1'b1, 1'b1);
        end
        set_size(DMAX);
        for (int k = 0; k < 70; k++) do_step(1'b0, 1'b1);

        phase = "sweep";
        for (int i = 0; i < 1500; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 40) begin
                do_step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end else if (r < 70) begin
                do_write((r < 55) ? 4 : 5,
                         (32'($urandom_range(0, m_depth + 1)) << 5) | 32'($urandom_range(0, 31)));
            end else if (r < 80) begin
                do_write(2, 32'($urandom_range(0, 7)));
                do_write(1, (r == 79) ? 32'(DMAX) << 3 : 32'($urandom_range(0, 9)) << 3);
                do_write(2, 32'h0);
            end else if (r < 85) begin
                do_write(2, 32'($urandom_range(0, 7)));
                do_write(0, $urandom());
            end else if (r < 90) begin
                do_write(3, (r == 85) ? 32'h0 : 32'h1);
            end else begin
                do_write((r < 95) ? 6 : 7, $urandom());
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule